// File: doc/BRIEF.md
# Two-Level Lookahead Adder, 16 Bits

This block adds two 16-bit operands and a carry-in without any carry rippling from bit to bit or from group to group. Every bit position first forms a generate term (both operand bits set) and a propagate term (exactly one operand bit set). The sixteen positions are split into four 4-bit groups. Each group resolves its own internal carries in parallel from the carry that enters it. Instead of a carry-out, each group reports a group generate and a group propagate.

A second lookahead unit, built with the same logic as a group, takes the four group generate and propagate pairs and the adder carry-in. From them it forms the carries that enter bits 4, 8 and 12 in parallel. It also forms the overall generate and propagate for all sixteen bits. The carry-out is taken from that overall pair. No lookahead gate has more than four inputs. The overall pair is brought out at the ports, so that several of these adders can sit under a third lookahead level.

The block is purely combinational. It has no clock, no reset and no state. Its outputs follow its inputs within the same cycle of whatever logic surrounds it.

Top module: `cla2_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `opa_i + opb_i + cin_i`, taken as unsigned integers.
- R2: `cout_o` equals bit 16 of the 17-bit result of `opa_i + opb_i + cin_i`.
- R3: `grp_prop_o` is 1 exactly when, in every one of the 16 bit positions, the two operand bits differ (`opa_i ^ opb_i` is all ones). Otherwise it is 0.
- R4: `grp_gen_o` is 1 exactly when `opa_i + opb_i` alone reaches 2^16 or more. `cin_i` has no effect on it.
- R5: `grp_gen_o` and `grp_prop_o` are never 1 together.
- R6: `cout_o` always equals `grp_gen_o OR (grp_prop_o AND cin_i)`, so the adder can be cascaded through its group pair.
- R7: When all 16 positions propagate, a carry-in of 1 gives `sum_o` = 0x0000 with `cout_o` = 1, and a carry-in of 0 gives `sum_o` = 0xFFFF with `cout_o` = 0.
- R8: The carry that enters each 4-bit group (bits 4, 8 and 12) equals the carry out of the lower bits of `opa_i + opb_i + cin_i`. This is seen at the ports as the lowest sum bit of that group.
- R9: The outputs depend only on the present inputs. A new operand pair gives the correct outputs before the next clock edge of the surrounding logic. Nothing from earlier operands is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 16 | First operand |
| opb_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |
| grp_gen_o | output | 1 | Generate over all 16 bits, for a higher lookahead level |
| grp_prop_o | output | 1 | Propagate over all 16 bits, for a higher lookahead level |

## Verification
The case that is hardest to reach from the ports is a long propagate chain. Here a carry that starts low, or comes from `cin_i`, must pass through two or more group boundaries by way of the second-level terms. Uniform random operands almost never produce twelve or more propagating positions in a row. The stimulus therefore builds many operand pairs as a random word and its complement. It then plants one or two generate or kill positions at random spots. Directed vectors place the carry exactly at the 4-, 8- and 12-bit boundaries, and also cover the fully propagating word with both carry-in values.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Largest number of inputs any lookahead gate may have; it also fixes
    // the group width and the number of groups under one second-level unit.
    localparam int unsigned LA_FANIN = 4;

    // Generate / propagate pair for one bit or one group of bits.
    typedef struct packed {
        logic gen;
        logic prop;
    } pg_t;

endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg
    import cla_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output pg_t  [W-1:0] pg_o
);

    // One generate / propagate cell per bit position.
    for (genvar k = 0; k < W; k++) begin : g_bit
        pg_t cell_d;
        always_comb begin
            cell_d.gen  = a_i[k] & b_i[k];
            cell_d.prop = a_i[k] ^ b_i[k];
        end
        assign pg_o[k] = cell_d;
    end

endmodule

// File: rtl/cla_la_unit.sv
module cla_la_unit
    import cla_pkg::*;
(
    input  pg_t  [3:0] pg_i,
    input  logic       cin_i,
    output logic [3:0] carry_o,   // carry into each of the four positions
    output pg_t        blk_o      // combined pair over the four positions
);

    // The block pair does not depend on the carry, so it is kept in its own
    // process; then a parent can feed carry_o back from blk_o without a loop.
    pg_t blk_d;
    always_comb begin
        blk_d.gen  = pg_i[3].gen
                   | (pg_i[3].prop & pg_i[2].gen)
                   | (pg_i[3].prop & pg_i[2].prop & pg_i[1].gen)
                   | (pg_i[3].prop & pg_i[2].prop & pg_i[1].prop & pg_i[0].gen);
        blk_d.prop = pg_i[3].prop & pg_i[2].prop & pg_i[1].prop & pg_i[0].prop;
    end
    assign blk_o = blk_d;

    // Carries into positions 1..3, each a sum of products of at most four
    // literals, all derived straight from cin_i.
    logic [3:0] carry_d;
    always_comb begin
        carry_d[0] = cin_i;
        carry_d[1] = pg_i[0].gen
                   | (pg_i[0].prop & cin_i);
        carry_d[2] = pg_i[1].gen
                   | (pg_i[1].prop & pg_i[0].gen)
                   | (pg_i[1].prop & pg_i[0].prop & cin_i);
        carry_d[3] = pg_i[2].gen
                   | (pg_i[2].prop & pg_i[1].gen)
                   | (pg_i[2].prop & pg_i[1].prop & pg_i[0].gen)
                   | (pg_i[2].prop & pg_i[1].prop & pg_i[0].prop & cin_i);
    end
    assign carry_o = carry_d;

endmodule

// File: rtl/cla2_adder.sv
module cla2_adder
    import cla_pkg::*;
#(
    parameter int unsigned GRP_W = 4,
    parameter int unsigned N_GRP = 4
) (
    input  logic [GRP_W*N_GRP-1:0] opa_i,
    input  logic [GRP_W*N_GRP-1:0] opb_i,
    input  logic                   cin_i,
    output logic [GRP_W*N_GRP-1:0] sum_o,
    output logic                   cout_o,
    output logic                   grp_gen_o,
    output logic                   grp_prop_o
);

    localparam int unsigned WIDTH = GRP_W * N_GRP;

    // The lookahead units are built for the fan-in limit; other shapes are refused.
    if (GRP_W != LA_FANIN || N_GRP != LA_FANIN) begin : g_bad_shape
        $error("cla2_adder: GRP_W and N_GRP must both equal the lookahead fan-in");
    end

    pg_t  [WIDTH-1:0] bit_pg;
    pg_t  [N_GRP-1:0] grp_pg;
    pg_t              all_pg;
    logic [N_GRP-1:0] grp_cin;   // carry entering each group
    logic [WIDTH-1:0] bit_cin;   // carry entering each bit

    cla_bit_pg #(.W(WIDTH)) u_bit_pg (
        .a_i  (opa_i),
        .b_i  (opb_i),
        .pg_o (bit_pg)
    );

    // First level: one lookahead unit per group.
    for (genvar gi = 0; gi < N_GRP; gi++) begin : g_grp
        cla_la_unit u_grp (
            .pg_i    (bit_pg[gi*GRP_W +: GRP_W]),
            .cin_i   (grp_cin[gi]),
            .carry_o (bit_cin[gi*GRP_W +: GRP_W]),
            .blk_o   (grp_pg[gi])
        );
    end

    // Second level: same unit, fed by the group pairs.
    cla_la_unit u_top (
        .pg_i    (grp_pg),
        .cin_i   (cin_i),
        .carry_o (grp_cin),
        .blk_o   (all_pg)
    );

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             cout;
    } res_t;

    res_t res_d;
    always_comb begin
        for (int k = 0; k < WIDTH; k++) begin
            res_d.sum[k] = bit_pg[k].prop ^ bit_cin[k];
        end
        // Final carry from the overall pair keeps fan-in within the limit.
        res_d.cout = all_pg.gen | (all_pg.prop & cin_i);
    end

    assign sum_o      = res_d.sum;
    assign cout_o     = res_d.cout;
    assign grp_gen_o  = all_pg.gen;
    assign grp_prop_o = all_pg.prop;

endmodule

// File: rtl/cla2_adder_chk.sv
module cla2_adder_chk #(
    parameter int unsigned GRP_W = 4,
    parameter int unsigned N_GRP = 4
) (
    input logic [GRP_W*N_GRP-1:0] opa_i,
    input logic [GRP_W*N_GRP-1:0] opb_i,
    input logic                   cin_i,
    input logic [GRP_W*N_GRP-1:0] sum_o,
    input logic                   cout_o,
    input logic                   grp_gen_o,
    input logic                   grp_prop_o,
    input logic [N_GRP-1:0]       grp_cin
);

    localparam int unsigned WIDTH = GRP_W * N_GRP;

    logic [WIDTH:0] ref_full;
    logic [WIDTH:0] ref_nocin;

    always_comb begin
        ref_full  = {1'b0, opa_i} + {1'b0, opb_i} + {{WIDTH{1'b0}}, cin_i};
        ref_nocin = {1'b0, opa_i} + {1'b0, opb_i};

        AST_SUM_MATCH: assert (sum_o == ref_full[WIDTH-1:0]) else $error("sum mismatch"); // R1
        AST_COUT_MATCH: assert (cout_o == ref_full[WIDTH]) else $error("carry-out mismatch"); // R2
        AST_PROP_ALL: assert (grp_prop_o == (&(opa_i ^ opb_i))) else $error("group propagate wrong"); // R3
        AST_GEN_NO_CIN: assert (grp_gen_o == ref_nocin[WIDTH]) else $error("group generate wrong"); // R4
        AST_GEN_PROP_EXCL: assert (!(grp_gen_o && grp_prop_o)) else $error("generate and propagate both set"); // R5
        AST_CASCADE: assert (cout_o == (grp_gen_o | (grp_prop_o & cin_i))) else $error("cascade law broken"); // R6
        if (&(opa_i ^ opb_i)) begin
            AST_FULL_CHAIN: assert ({cout_o, sum_o} == {cin_i, {WIDTH{~cin_i}}}) else $error("full chain wrong"); // R7
        end
        for (int k = 1; k < N_GRP; k++) begin
            logic [WIDTH:0] msk;
            logic [WIDTH:0] part;
            msk  = ({{WIDTH{1'b0}}, 1'b1} << (k * GRP_W)) - 1'b1;
            part = ({1'b0, opa_i} & msk) + ({1'b0, opb_i} & msk) + {{WIDTH{1'b0}}, cin_i};
            AST_GROUP_CARRY: assert (grp_cin[k] == part[k * GRP_W]) else $error("group carry wrong"); // R8
        end
    end

endmodule

bind cla2_adder cla2_adder_chk #(.GRP_W(GRP_W), .N_GRP(N_GRP)) u_chk (
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .cin_i      (cin_i),
    .sum_o      (sum_o),
    .cout_o     (cout_o),
    .grp_gen_o  (grp_gen_o),
    .grp_prop_o (grp_prop_o),
    .grp_cin    (grp_cin)
);

// File: tb/cla2_adder_tb.sv
module cla2_adder_tb;

    localparam int unsigned W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout, ggen, gprop;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    cla2_adder u_dut (
        .opa_i      (opa),
        .opb_i      (opb),
        .cin_i      (cin),
        .sum_o      (sum),
        .cout_o     (cout),
        .grp_gen_o  (ggen),
        .grp_prop_o (gprop)
    );

    typedef struct {
        logic [W-1:0] a, b;
        logic         c;
        logic [W-1:0] e_sum;
        logic         e_cout, e_gen, e_prop;
        string        tag;
    } item_t;

    item_t sb_q[$];

    // Driver: applies one vector after a rising edge and records what the ports must show.
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic c, input string tag);
        item_t it;
        logic [W:0] full, nocin;
        @(posedge clk);
        #1;
        opa = a; opb = b; cin = c;
        full  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
        nocin = {1'b0, a} + {1'b0, b};
        it.a = a; it.b = b; it.c = c;
        it.e_sum  = full[W-1:0];
        it.e_cout = full[W];
        it.e_gen  = nocin[W];
        it.e_prop = &(a ^ b);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic chk(input bit ok, input string what, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s a=%h b=%h actual=%h expected=%h", tag, what, opa, opb, act, exp);
        end
    endtask

    // Monitor: compares the settled outputs at the falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            chk(sum == it.e_sum, "R1 sum", it.tag, sum, it.e_sum);
            chk(cout == it.e_cout, "R2 cout", it.tag, {15'd0, cout}, {15'd0, it.e_cout});
            chk(gprop == it.e_prop, "R3 group prop", it.tag, {15'd0, gprop}, {15'd0, it.e_prop});
            chk(ggen == it.e_gen, "R4 group gen", it.tag, {15'd0, ggen}, {15'd0, it.e_gen});
            chk(!(ggen && gprop), "R5 gen/prop exclusive", it.tag, {14'd0, ggen, gprop}, 16'd0);
            chk(cout == (ggen | (gprop & it.c)), "R6 cascade", it.tag, {15'd0, cout}, {15'd0, ggen | (gprop & it.c)});
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle state with zero inputs
        drive(16'h0000, 16'h0000, 1'b0, "R9 idle zeros");
        drive(16'h0000, 16'h0000, 1'b1, "R1 cin only");
        // R7: every position propagates
        drive(16'hA5C3, 16'h5A3C, 1'b1, "R7 chain cin1");
        drive(16'hA5C3, 16'h5A3C, 1'b0, "R7 chain cin0");
        drive(16'hFFFF, 16'h0000, 1'b1, "R7 ones cin1");
        drive(16'hFFFF, 16'h0000, 1'b0, "R7 ones cin0");
        // R8: carry placed at each group boundary
        drive(16'h000F, 16'h0001, 1'b0, "R8 into bit4");
        drive(16'h00FF, 16'h0001, 1'b0, "R8 into bit8");
        drive(16'h0FFF, 16'h0001, 1'b0, "R8 into bit12");
        drive(16'h0FFF, 16'h0000, 1'b1, "R8 cin to bit12");
        drive(16'h0F0F, 16'h00F1, 1'b0, "R8 two groups");
        drive(16'hFFFF, 16'h0001, 1'b0, "R2 wrap");
        drive(16'h8000, 16'h8000, 1'b0, "R4 top gen");
        drive(16'h8000, 16'h8000, 1'b1, "R4 top gen cin");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R2 max");
        // R9: back-to-back changes, nothing kept from the previous pair
        drive(16'hFFFF, 16'hFFFF, 1'b1, "R9 before");
        drive(16'h0001, 16'h0000, 1'b0, "R9 after");
        // Random operands, half of them long propagate chains
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] a, b;
            a = W'($urandom);
            if (n % 2 == 0) begin
                b = W'($urandom);
            end else begin
                b = ~a;
                if ($urandom % 3 != 0) b[$urandom % W] ^= 1'b1;
                if ($urandom % 4 == 0) b[$urandom % W] ^= 1'b1;
            end
            drive(a, b, 1'($urandom), (n % 2 == 0) ? "R1 random" : "R8 chain random");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule